// File: doc/BRIEF.md
# Watchdog Event Reset Router

This block sits between a watchdog timer and a processor core. When the watchdog reports a timeout with a single-cycle event pulse, the router looks at a software-programmed response mode and produces one of four outcomes. It can do nothing. It can send a non-maskable interrupt (NMI) pulse. It can send a local reset pulse. Or it can send an NMI pulse and then, after a programmable delay, a local reset pulse. The delay is counted in ticks of a slow divided clock. That clock is presented to the block as a tick enable in the fast clock domain.

Software sees one 32-bit register. It holds the response mode, a delay code, a sticky flag recording that an event arrived, a write-one-to-clear bit for that flag, and a lock bit. Once the lock is set, the configuration is frozen. Only the timer reset input can release it, and that input also returns every field to its reset value and aborts a pending delayed reset.

Top module: `wdr_router`

## Requirements
- R1: After the system reset, the register reads 0x0000_0080: mode 000, delay code 100, status 0, lock 0. Both output pulses are low.
- R2: Register layout. Bit 0 is the lock, bits 3..1 are the mode, bit 4 is the status, and bits 7..5 are the delay code. Bits 31..8 always read 0, and this includes the clear bit 9.
- R3: Modes 000, 001, 101, 110 and 111 produce no NMI and no local reset when an event arrives.
- R4: In mode 010, an event sampled at a clock edge makes `lrst_pulse` high for exactly the following cycle, and `nmi_pulse` stays low.
- R5: In mode 011, an event sampled at a clock edge makes `nmi_pulse` high for exactly the following cycle, and `lrst_pulse` stays low.
- R6: In mode 100, the NMI pulse follows the event as in R5. A single `lrst_pulse` follows in the cycle after the edge that samples the (2^BASE_LOG2 × 2^code)-th high `tick_en` counted after the event edge. Cycles with `tick_en` low do not count.
- R7: An event that arrives while a mode-100 delay is running produces no NMI and does not move the pending reset.
- R8: Any event sets the status bit, whatever the mode. A write with bit 9 = 1 clears it. A write with bit 9 = 0 leaves it unchanged.
- R9: When a status clear write and an event arrive in the same cycle, the status bit reads 1 afterwards.
- R10: While the lock reads 1, writes do not change the mode, delay or lock fields. A bit-9 clear still clears the status bit.
- R11: `timer_rst` returns the register to 0x0000_0080, which also releases the lock. It aborts a running delay, so no local reset pulse follows.
- R12: Writing bit 4 has no effect on the status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| timer_rst | input | 1 | Synchronous timer reset: restores fields, unlocks, aborts sequence |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data |
| wd_event | input | 1 | Single-cycle watchdog timeout pulse |
| tick_en | input | 1 | Divided-clock tick enable for the delay counter |
| nmi_pulse | output | 1 | Single-cycle NMI request |
| lrst_pulse | output | 1 | Single-cycle local reset request |

## Verification
The collision that matters most is a status-clear write landing in the same cycle as a new watchdog event. The bench raises the write strobe with bit 9 set and the event pulse together for one cycle. It then reads the register and expects the status bit to remain 1, because the event wins. A second collision is an event that arrives while a delayed reset is still counting. The bench injects it two cycles after the first event and judges the result by NMI count and by the exact cycle of the single reset pulse, which is computed from the tick pattern.

// File: rtl/wdr_pkg.sv
package wdr_pkg;

    localparam int FLD_W = 3;

    localparam logic [FLD_W-1:0] MODE_NONE = 3'b000;
    localparam logic [FLD_W-1:0] MODE_LRST = 3'b010;
    localparam logic [FLD_W-1:0] MODE_NMI  = 3'b011;
    localparam logic [FLD_W-1:0] MODE_SEQ  = 3'b100;

    localparam int B_LOCK   = 0;
    localparam int B_MODE   = 1;
    localparam int B_STAT   = 4;
    localparam int B_DLY    = 5;
    localparam int B_CLR    = 9;

    typedef struct packed {
        logic [FLD_W-1:0] mode;
        logic [FLD_W-1:0] dly;
        logic             stat;
        logic             lock;
    } cfg_t;

    localparam cfg_t CFG_RST = '{mode: MODE_NONE, dly: 3'b100, stat: 1'b0, lock: 1'b0};

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_LRST,
        ACT_NMI,
        ACT_SEQ
    } act_e;

endpackage

// File: rtl/wdr_cfg_regs.sv
module wdr_cfg_regs
    import wdr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        timer_rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        evt_seen,
    output cfg_t        cfg,
    output logic [31:0] rd_data
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        // configuration fields are frozen while locked
        if (wr_en && !cfg_q.lock) begin
            cfg_d.mode = wr_data[B_MODE +: FLD_W];
            cfg_d.dly  = wr_data[B_DLY  +: FLD_W];
            cfg_d.lock = wr_data[B_LOCK];
        end
        // clear works regardless of lock; a same-cycle event wins
        if (wr_en && wr_data[B_CLR]) begin
            cfg_d.stat = 1'b0;
        end
        if (evt_seen) begin
            cfg_d.stat = 1'b1;
        end
        if (timer_rst) begin
            cfg_d = CFG_RST;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CFG_RST;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        rd_data                    = '0;
        rd_data[B_LOCK]            = cfg_q.lock;
        rd_data[B_MODE +: FLD_W]   = cfg_q.mode;
        rd_data[B_STAT]            = cfg_q.stat;
        rd_data[B_DLY  +: FLD_W]   = cfg_q.dly;
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/wdr_mode_dec.sv
module wdr_mode_dec
    import wdr_pkg::*;
(
    input  logic [FLD_W-1:0] mode,
    output act_e             act
);

    always_comb begin
        case (mode)
            MODE_LRST: act = ACT_LRST;
            MODE_NMI:  act = ACT_NMI;
            MODE_SEQ:  act = ACT_SEQ;
            default:   act = ACT_NONE;   // off and all reserved codes
        endcase
    end

endmodule

// File: rtl/wdr_delay_seq.sv
module wdr_delay_seq #(
    parameter int BASE_LOG2 = 8,
    parameter int DLY_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             timer_rst,
    input  logic             start,
    input  logic [DLY_W-1:0] code,
    input  logic             tick_en,
    output logic             busy,
    output logic             done
);

    localparam int CNT_W = BASE_LOG2 + (1 << DLY_W);
    localparam int SH_W  = $clog2(CNT_W + 1);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic             busy;
        logic [DLY_W-1:0] code;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t st_d, st_q;
    logic [CNT_W-1:0] last_cnt;

    always_comb begin
        last_cnt = (ONE << (SH_W'(BASE_LOG2) + SH_W'(st_q.code))) - ONE;
        done     = st_q.busy && tick_en && (st_q.cnt == last_cnt) && !timer_rst;

        st_d = st_q;
        if (st_q.busy) begin
            if (tick_en) begin
                if (st_q.cnt == last_cnt) begin
                    st_d.busy = 1'b0;
                    st_d.cnt  = '0;
                end else begin
                    st_d.cnt = st_q.cnt + ONE;
                end
            end
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
            st_d.code = code;
        end
        if (timer_rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;

endmodule

// File: rtl/wdr_router.sv
module wdr_router
    import wdr_pkg::*;
#(
    parameter int BASE_LOG2 = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        timer_rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    input  logic        wd_event,
    input  logic        tick_en,
    output logic        nmi_pulse,
    output logic        lrst_pulse
);

    typedef struct packed {
        logic nmi;
        logic lrst;
    } out_t;

    cfg_t cfg;
    act_e act;
    logic seq_busy;
    logic seq_done;
    logic accept;
    out_t out_d, out_q;

    wdr_cfg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .timer_rst (timer_rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .evt_seen  (wd_event),
        .cfg       (cfg),
        .rd_data   (rd_data)
    );

    wdr_mode_dec u_dec (
        .mode (cfg.mode),
        .act  (act)
    );

    // an event is acted on only when no delayed reset is pending
    assign accept = wd_event && !timer_rst && !seq_busy;

    wdr_delay_seq #(
        .BASE_LOG2 (BASE_LOG2),
        .DLY_W     (FLD_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .timer_rst (timer_rst),
        .start     (accept && (act == ACT_SEQ)),
        .code      (cfg.dly),
        .tick_en   (tick_en),
        .busy      (seq_busy),
        .done      (seq_done)
    );

    always_comb begin
        out_d.nmi  = accept && ((act == ACT_NMI) || (act == ACT_SEQ));
        out_d.lrst = !timer_rst && (seq_done || (accept && (act == ACT_LRST)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign nmi_pulse  = out_q.nmi;
    assign lrst_pulse = out_q.lrst;

endmodule

// File: rtl/wdr_router_chk.sv
module wdr_router_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        timer_rst,
    input logic [31:0] rd_data,
    input logic        wd_event,
    input logic        nmi_pulse,
    input logic        lrst_pulse
);

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[31:8] == 24'h0) else $error("reserved bits nonzero"); // R2

    AST_NMI_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_pulse |-> $past(wd_event)) else $error("nmi without event"); // R5

    AST_NO_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        !(nmi_pulse && lrst_pulse)) else $error("nmi and reset together"); // R6

    AST_STATUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_event && !timer_rst) |=> rd_data[4]) else $error("status not set"); // R8

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[0] && !timer_rst) |=> ($stable(rd_data[7:5]) && $stable(rd_data[3:0])))
        else $error("locked field changed"); // R10

    AST_TRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        timer_rst |=> (rd_data == 32'h80 && !nmi_pulse && !lrst_pulse))
        else $error("timer reset incomplete"); // R11

endmodule

bind wdr_router wdr_router_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .timer_rst  (timer_rst),
    .rd_data    (rd_data),
    .wd_event   (wd_event),
    .nmi_pulse  (nmi_pulse),
    .lrst_pulse (lrst_pulse)
);

// File: tb/wdr_router_tb.sv
`timescale 1ns/1ps
module wdr_router_tb;

    localparam int BASE = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        timer_rst = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        wd_event = 1'b0;
    logic        tick_en = 1'b0;
    logic        nmi_pulse;
    logic        lrst_pulse;

    int cyc = 0, tper = 1;
    int nmi_n = 0, lrst_n = 0, nmi_at = 0, lrst_at = 0;
    int tests = 0, fails = 0;

    always #2 clk = ~clk;

    wdr_router #(.BASE_LOG2(BASE)) u_dut (
        .clk(clk), .rst_n(rst_n), .timer_rst(timer_rst), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .wd_event(wd_event),
        .tick_en(tick_en), .nmi_pulse(nmi_pulse), .lrst_pulse(lrst_pulse)
    );

    task automatic step();
        @(posedge clk);
        #1;
        cyc++;
        if (nmi_pulse)  begin nmi_n++;  nmi_at  = cyc; end
        if (lrst_pulse) begin lrst_n++; lrst_at = cyc; end
        tick_en = ((cyc % tper) == 0);
    endtask

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        wr_en = 1'b1; wr_data = d;
        step();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic evt();
        wd_event = 1'b1;
        step();
        wd_event = 1'b0;
    endtask

    task automatic trst();
        timer_rst = 1'b1;
        step();
        timer_rst = 1'b0;
    endtask

    task automatic clr_mon();
        nmi_n = 0; lrst_n = 0; nmi_at = 0; lrst_at = 0;
    endtask

    // cycle at which the reset is observed: Nth edge c > ev with (c-1)%tp==0
    function automatic int exp_lrst(input int ev, input int n, input int tp);
        int c = ev + 1;
        int k = 0;
        while (1) begin
            if (((c - 1) % tp) == 0) k++;
            if (k == n) return c;
            c++;
        end
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired (all R) act=%0d exp=done", cyc);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int ev;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk(rd_data == 32'h80, "R1 reset value", rd_data, 32'h80);
        chk(!nmi_pulse && !lrst_pulse, "R1 outputs low", {nmi_pulse, lrst_pulse}, 0);

        // R3 R4 R5 R6 mode sweep
        for (int m = 0; m < 8; m++) begin
            int en, el;
            wr({24'h0, 3'b100, 1'b0, 3'(m), 1'b0});
            clr_mon();
            evt();
            ev = cyc;
            repeat (4) step();
            en = (m == 3 || m == 4) ? 1 : 0;
            el = (m == 2) ? 1 : 0;
            chk(nmi_n == en, (m == 4) ? "R6 nmi count" : (m == 3) ? "R5 nmi count" : "R3 nmi count", nmi_n, en);
            chk(lrst_n == el, (m == 2) ? "R4 lrst count" : "R3 lrst count", lrst_n, el);
            if (en == 1) chk(nmi_at == ev, "R5 nmi cycle", nmi_at, ev);
            if (el == 1) chk(lrst_at == ev, "R4 lrst cycle", lrst_at, ev);
            chk(rd_data[4] == 1'b1, "R8 status set", rd_data[4], 1);
            repeat (80) step();
            wr(32'h280);
            chk(rd_data[4] == 1'b0, "R8 status clear", rd_data[4], 0);
        end

        // R6 delay sweep over all codes and two tick patterns
        for (int t = 0; t < 2; t++) begin
            for (int code = 0; code < 8; code++) begin
                int n, ex;
                tper = (t == 0) ? 1 : 3;
                wr({24'h0, 3'(code), 1'b0, 3'b100, 1'b0});
                step();
                clr_mon();
                evt();
                ev = cyc;
                n = (1 << BASE) << code;
                ex = exp_lrst(ev, n, tper);
                while (lrst_n == 0 && cyc < ex + 10) step();
                repeat (3) step();
                chk(lrst_at == ex, "R6 lrst cycle", lrst_at, ex);
                chk(lrst_n == 1, "R6 lrst count", lrst_n, 1);
                chk(nmi_n == 1 && nmi_at == ev, "R6 nmi cycle", nmi_at, ev);
            end
        end

        // R7 event during delay
        tper = 1;
        wr(32'h08);
        step();
        clr_mon();
        evt();
        ev = cyc;
        step();
        evt();
        repeat (8) step();
        chk(nmi_n == 1, "R7 nmi count", nmi_n, 1);
        chk(lrst_at == exp_lrst(ev, 1 << BASE, 1), "R7 lrst cycle", lrst_at, exp_lrst(ev, 1 << BASE, 1));
        chk(lrst_n == 1, "R7 lrst count", lrst_n, 1);

        // R8 write with clear bit 0; R12 bit4 write
        wr(32'h80);
        evt();
        wr(32'h80);
        chk(rd_data[4] == 1'b1, "R8 zero clear no effect", rd_data[4], 1);
        wr(32'h280);
        wr(32'h90);
        chk(rd_data[4] == 1'b0, "R12 bit4 write ignored", rd_data[4], 0);

        // R9 clear and event same cycle
        wr_en = 1'b1; wr_data = 32'h280; wd_event = 1'b1;
        step();
        wr_en = 1'b0; wr_data = '0; wd_event = 1'b0;
        chk(rd_data[4] == 1'b1, "R9 event beats clear", rd_data[4], 1);

        // R2 all-ones write
        wr(32'h0000_0280);
        wr(32'hFFFF_FFFF);
        chk(rd_data == 32'hEF, "R2 readback layout", rd_data, 32'hEF);
        trst();
        chk(rd_data == 32'h80, "R11 timer reset value", rd_data, 32'h80);

        // R10 lock
        wr(32'h47);
        chk(rd_data == 32'h47, "R10 lock write", rd_data, 32'h47);
        wr(32'h0);
        chk(rd_data == 32'h47, "R10 locked fields held", rd_data, 32'h47);
        evt();
        step();
        chk(rd_data == 32'h57, "R10 status under lock", rd_data, 32'h57);
        wr(32'h200);
        chk(rd_data == 32'h47, "R10 clear under lock", rd_data, 32'h47);
        trst();
        chk(rd_data == 32'h80, "R11 unlock", rd_data, 32'h80);

        // R11 abort of running delay
        wr(32'hE8);
        clr_mon();
        evt();
        repeat (10) step();
        trst();
        chk(rd_data == 32'h80, "R11 reset mid-sequence", rd_data, 32'h80);
        repeat (600) step();
        chk(lrst_n == 0, "R11 sequence aborted", lrst_n, 0);
        wr(32'h04);
        chk(rd_data == 32'h04, "R11 writable after reset", rd_data, 32'h04);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule